// File: doc/BRIEF.md
# Software Write-Protect Command Decoder

This block sits beside the page loader of a byte-wide nonvolatile memory. It sees every completed write cycle as an address/data pair and decides, in that same cycle, whether the byte may go on to the array. It matches fixed command writes across consecutive cycles. A three-write unlock sequence turns protection on and opens a window for one page load. A six-write sequence turns protection off after a programmed delay that stands in for the write-cycle time.

The protection flag would be nonvolatile in a real device. Here it is a register that takes the `prot_preset` input while reset is active, so a simulated power cycle can bring the saved state back. `prot_state` carries the live flag so the caller can save it. When protection is on, each page load needs a fresh unlock sequence: the window closes again when the loader reports that programming has finished.

Top module: `wp_cmd_decoder`

## Requirements
- R1: While `rst_n` is low, `prot_state` follows `prot_preset`. After release the command matcher is at its start and no load window is open.
- R2: While `prot_state` is 0, every write has `wr_permit`=1 and `cmd_swallow`=0, command writes included.
- R3: The writes AA@5555, 55@2AAA, A0@5555 (hex data@address), given on consecutive write strobes, set `prot_state` to 1 from the clock edge that takes the third write, whatever the earlier state. From that edge a load window is open.
- R4: While `prot_state` is 1 and no window is open, a write that is not a command step has `wr_permit`=0 and `cmd_swallow`=0.
- R5: While `prot_state` is 1 and no window is open, a write that matches the next expected command step, or AA@5555, has `cmd_swallow`=1 and `wr_permit`=0.
- R6: While protected, an open window permits at most PAGE_BYTES writes and blocks any write after those. Writes inside a window are never taken as commands.
- R7: A `load_done` pulse closes an open window. Outside a window `load_done` has no effect.
- R8: A write that breaks a sequence sends the matcher back to its start. If that write is AA@5555, it counts as the first step of a new sequence.
- R9: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555 clear `prot_state`. The flag stays 1 for the first TWC_CYCLES-1 edges after the edge that takes the sixth write and reads 0 after edge TWC_CYCLES.
- R10: Only address bits [14:0] are compared. Any bits above bit 14 are ignored.
- R11: An unlock sequence that completes while a disable is pending cancels the disable. Protection stays on and the window opens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_preset | input | 1 | Protection value loaded during reset (saved flag) |
| wr_valid | input | 1 | A completed write cycle is presented this cycle |
| wr_addr | input | ADDR_W | Address of the write |
| wr_data | input | 8 | Data byte of the write |
| load_done | input | 1 | Page loader reports that programming has finished |
| wr_permit | output | 1 | The current write may reach the array |
| cmd_swallow | output | 1 | The current write is a command and is kept from the array |
| prot_state | output | 1 | Current protection flag |

## Verification
`wr_permit` and `cmd_swallow` are combinational in the cycle of the write. The bench drives each write at a falling edge and samples the outputs 1 ns later, before the rising edge that takes the write. Protection set by an unlock shows on `prot_state` after the edge that takes the third write. A disable is checked on every edge: the flag must still be 1 on the first TWC_CYCLES-1 edges after the sixth write and 0 from edge TWC_CYCLES. Window capacity and closing are checked with writes placed before and after each `load_done` pulse. The bench also sweeps every data value at both key addresses, with the expected swallow computed from the byte value.

// File: rtl/wpcd_pkg.sv
`timescale 1ns/1ps
package wpcd_pkg;
   localparam int KEY_AW = 15;
   localparam logic [KEY_AW-1:0] KEY_ADR_P = 15'h5555;
   localparam logic [KEY_AW-1:0] KEY_ADR_Q = 15'h2AAA;
   localparam logic [7:0] KD_LEAD    = 8'hAA;
   localparam logic [7:0] KD_FOLLOW  = 8'h55;
   localparam logic [7:0] KD_LOCK    = 8'hA0;
   localparam logic [7:0] KD_BRANCH  = 8'h80;
   localparam logic [7:0] KD_RELEASE = 8'h20;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_L1   = 3'd1,
      ST_L2   = 3'd2,
      ST_U3   = 3'd3,
      ST_U4   = 3'd4,
      ST_U5   = 3'd5
   } seq_t;
endpackage

// File: rtl/wpcd_seq_match.sv
`timescale 1ns/1ps
module wpcd_seq_match
   import wpcd_pkg::*;
#(
   parameter int ADDR_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   output logic              cmd_hit,
   output logic              unlock_fire,
   output logic              disable_fire
);
   logic [KEY_AW-1:0] key_addr;

   generate
      if (ADDR_W > KEY_AW) begin : g_wide
         logic unused_hi;
         assign unused_hi = ^wr_addr[ADDR_W-1:KEY_AW];
         assign key_addr  = wr_addr[KEY_AW-1:0];
      end else begin : g_exact
         assign key_addr = wr_addr;
      end
   endgenerate

   seq_t st, st_nxt;
   logic go, adv;
   logic k_lead, k_follow, k_lock, k_branch, k_release;

   assign go        = en && wr_valid;
   assign k_lead    = (key_addr == KEY_ADR_P) && (wr_data == KD_LEAD);
   assign k_follow  = (key_addr == KEY_ADR_Q) && (wr_data == KD_FOLLOW);
   assign k_lock    = (key_addr == KEY_ADR_P) && (wr_data == KD_LOCK);
   assign k_branch  = (key_addr == KEY_ADR_P) && (wr_data == KD_BRANCH);
   assign k_release = (key_addr == KEY_ADR_P) && (wr_data == KD_RELEASE);

   always_comb begin
      st_nxt       = st;
      adv          = 1'b0;
      unlock_fire  = 1'b0;
      disable_fire = 1'b0;
      if (go) begin
         case (st)
            ST_IDLE: if (k_lead)   begin st_nxt = ST_L1; adv = 1'b1; end
            ST_L1:   if (k_follow) begin st_nxt = ST_L2; adv = 1'b1; end
            ST_L2: begin
               if (k_lock) begin
                  st_nxt = ST_IDLE; adv = 1'b1; unlock_fire = 1'b1;
               end else if (k_branch) begin
                  st_nxt = ST_U3; adv = 1'b1;
               end
            end
            ST_U3:   if (k_lead)   begin st_nxt = ST_U4; adv = 1'b1; end
            ST_U4:   if (k_follow) begin st_nxt = ST_U5; adv = 1'b1; end
            ST_U5: begin
               if (k_release) begin
                  st_nxt = ST_IDLE; adv = 1'b1; disable_fire = 1'b1;
               end
            end
            default: st_nxt = ST_IDLE;
         endcase
         if (!adv) st_nxt = k_lead ? ST_L1 : ST_IDLE;
      end
   end

   assign cmd_hit = go && (adv || k_lead);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nxt;
   end

   // R8: a lead write outside the second sequence branch restarts at step one
   a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
      go && k_lead && (st != ST_U3) |=> st == ST_L1);
   // R6: matcher frozen while a window is open
   a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(st));
endmodule

// File: rtl/wpcd_window.sv
`timescale 1ns/1ps
module wpcd_window #(
   parameter int PAGE_BYTES = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic open_req,
   input  logic take_req,
   input  logic load_done,
   output logic win_open,
   output logic win_room
);
   localparam int CW = $clog2(PAGE_BYTES + 1);

   logic [CW-1:0] cnt;

   assign win_room = cnt < CW'(PAGE_BYTES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_open <= 1'b0;
         cnt      <= '0;
      end else if (open_req) begin
         win_open <= 1'b1;
         cnt      <= '0;
      end else if (win_open && load_done) begin
         win_open <= 1'b0;
      end else if (win_open && take_req && win_room) begin
         cnt <= cnt + CW'(1);
      end
   end

   a_r6_cap: assert property (@(posedge clk) disable iff (!rst_n)
      win_open |-> cnt <= CW'(PAGE_BYTES));
   a_r7_close: assert property (@(posedge clk) disable iff (!rst_n)
      win_open && load_done && !open_req |=> !win_open);
   a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !win_open && !open_req |=> !win_open);
endmodule

// File: rtl/wpcd_prot_flag.sv
`timescale 1ns/1ps
module wpcd_prot_flag #(
   parameter int TWC_CYCLES = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic preset,
   input  logic set_req,
   input  logic clr_req,
   output logic prot_q
);
   generate
      if (TWC_CYCLES == 0) begin : g_instant
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       prot_q <= preset;
            else if (set_req) prot_q <= 1'b1;
            else if (clr_req) prot_q <= 1'b0;
         end
      end else begin : g_delayed
         localparam int TW = $clog2(TWC_CYCLES + 1);
         logic          pend;
         logic [TW-1:0] tmr;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prot_q <= preset;
               pend   <= 1'b0;
               tmr    <= '0;
            end else if (set_req) begin
               prot_q <= 1'b1;
               pend   <= 1'b0;
               tmr    <= '0;
            end else if (clr_req) begin
               pend <= 1'b1;
               tmr  <= TW'(TWC_CYCLES);
            end else if (pend) begin
               if (tmr == TW'(1)) begin
                  prot_q <= 1'b0;
                  pend   <= 1'b0;
                  tmr    <= '0;
               end else begin
                  tmr <= tmr - TW'(1);
               end
            end
         end

         // R9: flag holds through the cycle after a disable request
         a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
            clr_req && !set_req && prot_q |=> prot_q);
         // R11: a set request always wins and cancels any pending clear
         a_r11_set: assert property (@(posedge clk) disable iff (!rst_n)
            set_req |=> prot_q && !pend);
      end
   endgenerate
endmodule

// File: rtl/wp_cmd_decoder.sv
`timescale 1ns/1ps
module wp_cmd_decoder #(
   parameter int ADDR_W     = 15,
   parameter int PAGE_BYTES = 128,
   parameter int TWC_CYCLES = 5000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prot_preset,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              load_done,
   output logic              wr_permit,
   output logic              cmd_swallow,
   output logic              prot_state
);
   generate
      if (ADDR_W < wpcd_pkg::KEY_AW) begin : g_bad_aw
         $error("wp_cmd_decoder: ADDR_W must be at least 15");
      end
      if (PAGE_BYTES < 1) begin : g_bad_page
         $error("wp_cmd_decoder: PAGE_BYTES must be at least 1");
      end
      if (TWC_CYCLES < 0) begin : g_bad_twc
         $error("wp_cmd_decoder: TWC_CYCLES must not be negative");
      end
   endgenerate

   logic cmd_hit, unlock_fire, disable_fire;
   logic win_open, win_room;

   wpcd_seq_match #(.ADDR_W(ADDR_W)) u_match (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (!win_open),
      .wr_valid     (wr_valid),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .cmd_hit      (cmd_hit),
      .unlock_fire  (unlock_fire),
      .disable_fire (disable_fire)
   );

   wpcd_window #(.PAGE_BYTES(PAGE_BYTES)) u_window (
      .clk       (clk),
      .rst_n     (rst_n),
      .open_req  (unlock_fire),
      .take_req  (wr_valid),
      .load_done (load_done),
      .win_open  (win_open),
      .win_room  (win_room)
   );

   wpcd_prot_flag #(.TWC_CYCLES(TWC_CYCLES)) u_prot (
      .clk     (clk),
      .rst_n   (rst_n),
      .preset  (prot_preset),
      .set_req (unlock_fire),
      .clr_req (disable_fire),
      .prot_q  (prot_state)
   );

   assign cmd_swallow = prot_state && cmd_hit;
   assign wr_permit   = wr_valid && !cmd_swallow &&
                        (!prot_state || (win_open && win_room));

   a_r2_open_pass: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !prot_state |-> wr_permit && !cmd_swallow);
   a_r4_closed_block: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && prot_state && !win_open |-> !wr_permit);
   a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_permit && cmd_swallow));
   a_r3_arm: assert property (@(posedge clk) disable iff (!rst_n)
      unlock_fire |=> prot_state && win_open);
   a_r6_no_cmd_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      win_open |-> !cmd_swallow);
endmodule

// File: tb/test_wp_cmd_decoder.sv
`timescale 1ns/1ps
module test_wp_cmd_decoder;
   localparam int AW = 16;
   localparam int PB = 4;
   localparam int TW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          prot_preset = 1'b0;
   logic          wr_valid = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic          load_done = 1'b0;
   logic          wr_permit, cmd_swallow, prot_state;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   wp_cmd_decoder #(.ADDR_W(AW), .PAGE_BYTES(PB), .TWC_CYCLES(TW)) i_wp_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .prot_preset(prot_preset),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
      .load_done(load_done), .wr_permit(wr_permit),
      .cmd_swallow(cmd_swallow), .prot_state(prot_state)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d,
                     input logic ep, input logic es, input string req);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_data = d;
      #1;
      chk({req, " permit"}, wr_permit, ep);
      chk({req, " swallow"}, cmd_swallow, es);
      @(posedge clk);
      #1 wr_valid = 1'b0;
   endtask

   task automatic pulse_done();
      @(negedge clk); load_done = 1'b1;
      @(posedge clk); #1 load_done = 1'b0;
   endtask

   task automatic do_reset(input logic pre);
      @(negedge clk); rst_n = 1'b0; prot_preset = pre;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   task automatic unlock_seq(input logic ep, input logic es, input string req);
      wr(16'h5555, 8'hAA, ep, es, req);
      wr(16'h2AAA, 8'h55, ep, es, req);
      wr(16'h5555, 8'hA0, ep, es, req);
   endtask

   task automatic disable_seq(input logic ep, input logic es, input string req);
      wr(16'h5555, 8'hAA, ep, es, req);
      wr(16'h2AAA, 8'h55, ep, es, req);
      wr(16'h5555, 8'h80, ep, es, req);
      wr(16'h5555, 8'hAA, ep, es, req);
      wr(16'h2AAA, 8'h55, ep, es, req);
      wr(16'h5555, 8'h20, ep, es, req);
   endtask

   initial begin
      // R1: fresh device, protection preset off
      do_reset(1'b0);
      chk("R1 reset flag", prot_state, 1'b0);
      wr(16'h0123, 8'h3C, 1'b1, 1'b0, "R1 first write");

      // R2: unprotected sweep of every data value at a key address
      for (int d = 0; d < 256; d++) wr(16'h5555, 8'(d), 1'b1, 1'b0, "R2 sweep");
      unlock_seq(1'b1, 1'b0, "R2 commands forwarded");
      chk("R3 set from off", prot_state, 1'b1);

      // R6: window holds PB writes, command-shaped bytes are data
      wr(16'h0200, 8'h11, 1'b1, 1'b0, "R6 byte0");
      wr(16'h5555, 8'hAA, 1'b1, 1'b0, "R6 cmd-shaped byte");
      wr(16'h0201, 8'h22, 1'b1, 1'b0, "R6 byte2");
      wr(16'h0202, 8'h33, 1'b1, 1'b0, "R6 byte3");
      wr(16'h0203, 8'h44, 1'b0, 1'b0, "R6 over capacity");
      pulse_done();
      wr(16'h0204, 8'h55, 1'b0, 1'b0, "R7 closed after done");

      // R4 and R5: protected sweeps
      for (int d = 0; d < 256; d++) wr(16'h2AAA, 8'(d), 1'b0, 1'b0, "R4 sweep");
      for (int d = 0; d < 256; d++)
         wr(16'h5555, 8'(d), 1'b0, (d == 8'hAA), "R5 sweep");

      // R7: done pulse with no window open changes nothing
      pulse_done();
      wr(16'h0600, 8'h61, 1'b0, 1'b0, "R7 stray done");

      // R8: broken sequence, no resume, restart on lead write
      wr(16'h5555, 8'hAA, 1'b0, 1'b1, "R8 step1");
      wr(16'h2AAA, 8'h55, 1'b0, 1'b1, "R8 step2");
      wr(16'h0100, 8'h12, 1'b0, 1'b0, "R8 mismatch");
      wr(16'h5555, 8'hA0, 1'b0, 1'b0, "R8 no resume");
      wr(16'h5555, 8'hAA, 1'b0, 1'b1, "R8 lead");
      wr(16'h5555, 8'hAA, 1'b0, 1'b1, "R8 restart");
      wr(16'h2AAA, 8'h55, 1'b0, 1'b1, "R8 follow");
      wr(16'h5555, 8'hA0, 1'b0, 1'b1, "R8 lock");
      chk("R3 set from on", prot_state, 1'b1);
      wr(16'h0300, 8'h5A, 1'b1, 1'b0, "R3 window write");
      pulse_done();

      // R10: upper address bit ignored, low bits compared exactly
      wr(16'h5554, 8'hAA, 1'b0, 1'b0, "R10 near miss");
      wr(16'hD555, 8'hAA, 1'b0, 1'b1, "R10 step1");
      wr(16'hAAAA, 8'h55, 1'b0, 1'b1, "R10 step2");
      wr(16'hD555, 8'hA0, 1'b0, 1'b1, "R10 step3");
      wr(16'h8300, 8'h66, 1'b1, 1'b0, "R10 window write");
      pulse_done();

      // R9: disable takes effect TW edges after the sixth write
      disable_seq(1'b0, 1'b1, "R9 commands");
      for (int i = 1; i < TW; i++) begin
         @(posedge clk); #1;
         chk("R9 still protected", prot_state, 1'b1);
      end
      @(posedge clk); #1;
      chk("R9 cleared", prot_state, 1'b0);
      wr(16'h0400, 8'h99, 1'b1, 1'b0, "R9 open write");

      // R11: unlock during pending disable keeps protection
      unlock_seq(1'b1, 1'b0, "R11 arm");
      pulse_done();
      disable_seq(1'b0, 1'b1, "R11 disable");
      unlock_seq(1'b0, 1'b1, "R11 re-lock");
      repeat (TW + 4) @(posedge clk);
      #1;
      chk("R11 protection kept", prot_state, 1'b1);
      wr(16'h0500, 8'h42, 1'b1, 1'b0, "R11 window write");
      pulse_done();

      // R1: power cycle with saved flag
      do_reset(1'b1);
      chk("R1 preset on", prot_state, 1'b1);
      wr(16'h0100, 8'h77, 1'b0, 1'b0, "R1 blocked after preset");
      do_reset(1'b0);
      chk("R1 preset off", prot_state, 1'b0);
      wr(16'h0100, 8'h77, 1'b1, 1'b0, "R1 open after preset");

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #1000000;
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule